// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small data cache placed between a processor-side word port and a next-level memory that moves whole blocks. It keeps four lines of 16 bytes each, which is half of a 128-byte backing store. Every processor address is split into a tag, a line index and an offset. The line the index selects is checked for a matching tag. A match is served straight from the line and does not touch the next level.

On a miss, the line the index selects is replaced. If the line is valid and has been modified since it was filled, its whole block is first written out to the next level. The missing block is then fetched into the line, and the access completes as a hit. Stores change only the cached copy and mark the line dirty. A store that misses fetches the block first and then merges the word into it. The next-level port carries one 16-byte block per request, under a request/acknowledge handshake.

Top module: `dmc_top`

## Requirements
- R1: The address is decoded as follows: bits [1:0] are a byte offset and are ignored; bits [3:2] select one of four 32-bit words in the block, with word 0 in block bits [31:0]; bits [5:4] are the line index; bit [6] is the tag. The next-level block number `mem_blk` is address bits [6:4].
- R2: After reset every line is invalid. The first access to any line misses. An invalid line is never written back, whatever its data holds.
- R3: A read hit returns the addressed word. `cpu_ready` is high for one cycle, in the second cycle after the cycle in which `cpu_req` was sampled, and the hit raises no next-level request.
- R4: A read miss on a line that is invalid or clean issues exactly one block read (`mem_we`=0) for the requested block. Afterwards the addressed word is returned from the fetched data. `mem_req`, `mem_we` and `mem_blk` stay stable until `mem_ack`.
- R5: A store hit writes only the cached word and sets the line's dirty bit. The next-level memory is unchanged. A completed store returns its own write data on `cpu_rdata`.
- R6: A miss on a valid dirty line first issues one block write (`mem_we`=1) carrying the victim's block number and all of its data. The refill read for the requested block is issued only after that write is acknowledged.
- R7: A store miss fetches the block, merges the store word into it, and leaves the line dirty. Later reads of that word hit and return the stored value. The other words keep their fetched values.
- R8: `cpu_stall` is high while a write-back or a refill is in progress. It is never high in the same cycle as `cpu_ready`, and it stays low during a hit.
- R9: A miss on a valid clean line issues no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Access request, sampled while the cache is idle |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 7 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, or the store data for a store, valid with cpu_ready |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_stall | output | 1 | High while a miss is being served at the next level |
| mem_req | output | 1 | Next-level block request |
| mem_we | output | 1 | 1 = block write-back, 0 = block read |
| mem_blk | output | 3 | Next-level block number |
| mem_wdata | output | 128 | Block data for a write-back |
| mem_rdata | input | 128 | Block data returned for a read |
| mem_ack | input | 1 | One-cycle acknowledge that completes the request |

## Verification
The hardest case to reach from the ports is a dirty eviction. It needs a line that was filled, then modified by a store, and then hit by an aliasing address with the other tag. A second, related case is a store miss into a line that has never been valid, whose merged word must later appear in a write-back. The stimulus builds these states step by step: it fills line 0, stores into it, and evicts it with the aliasing block. It then does a store miss into an empty line and evicts that line again. A bench-side backing memory logs the order of every block transfer, so the write-before-read order and the written data can be checked.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_COMPARE,
    ST_WRITEBACK,
    ST_REFILL,
    ST_RESPOND
  } ctrl_state_e;
endpackage

// File: rtl/dmc_lines.sv
module dmc_lines #(
  parameter int LINES = 4,
  parameter int TAG_W = 1,
  parameter int WORD_W = 32,
  parameter int WORDS = 4,
  localparam int IDX_W = $clog2(LINES),
  localparam int SEL_W = $clog2(WORDS),
  localparam int BLK_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  output logic              lk_valid,
  output logic              lk_dirty,
  output logic [TAG_W-1:0]  lk_tag,
  output logic [BLK_W-1:0]  lk_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [BLK_W-1:0]  fill_data,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [WORD_W-1:0] wr_data
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q  [LINES];
  logic [BLK_W-1:0] data_q [LINES];

  assign lk_valid = valid_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];
  assign lk_tag   = tag_q[lk_idx];
  assign lk_data  = data_q[lk_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      for (int i = 0; i < LINES; i++) tag_q[i] <= '0;
    end else if (fill_en) begin
      valid_q[lk_idx] <= 1'b1;
      dirty_q[lk_idx] <= 1'b0;
      tag_q[lk_idx]   <= fill_tag;
    end else if (wr_en) begin
      dirty_q[lk_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) data_q[lk_idx] <= fill_data;
    else if (wr_en) data_q[lk_idx][wr_sel*WORD_W +: WORD_W] <= wr_data;
  end

  AST_FILL_LEAVES_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (valid_q[$past(lk_idx)] && !dirty_q[$past(lk_idx)])); // R4
  AST_STORE_MARKS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !fill_en) |=> dirty_q[$past(lk_idx)]); // R5
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int LINES = 4,
  localparam int WORDS = BLOCK_BYTES * 8 / WORD_W,
  localparam int BYTE_OFF = $clog2(WORD_W / 8),
  localparam int SEL_W = $clog2(WORDS),
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int BN_W = ADDR_W - OFF_W,
  localparam int BLK_W = BLOCK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BN_W-1:0]   mem_blk,
  input  logic              mem_ack,
  output logic [IDX_W-1:0]  lk_idx,
  input  logic              lk_valid,
  input  logic              lk_dirty,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [BLK_W-1:0]  lk_data,
  output logic              fill_en,
  output logic [TAG_W-1:0]  fill_tag,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [WORD_W-1:0] wr_data
);
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [SEL_W-1:0] addr_sel(input logic [ADDR_W-1:0] a);
    return a[BYTE_OFF +: SEL_W];
  endfunction
  function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] b,
                                                  input logic [SEL_W-1:0] s);
    return b[s*WORD_W +: WORD_W];
  endfunction

  ctrl_state_e state_q, state_d;
  logic              req_we;
  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [SEL_W-1:0]  req_sel;
  logic [WORD_W-1:0] req_wdata;
  logic [WORD_W-1:0] rdata_q;
  logic              unused_byte_bits;

  // named internal events
  logic tag_match, lookup_hit, lookup_miss, victim_dirty;

  assign unused_byte_bits = ^cpu_addr[BYTE_OFF-1:0];
  assign tag_match    = lk_valid && (lk_tag == req_tag);
  assign lookup_hit   = (state_q == ST_COMPARE) && tag_match;
  assign lookup_miss  = (state_q == ST_COMPARE) && !tag_match;
  assign victim_dirty = lk_valid && lk_dirty;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:      if (cpu_req) state_d = ST_COMPARE;
      ST_COMPARE:   if (tag_match) state_d = ST_RESPOND;
                    else if (victim_dirty) state_d = ST_WRITEBACK;
                    else state_d = ST_REFILL;
      ST_WRITEBACK: if (mem_ack) state_d = ST_REFILL;
      ST_REFILL:    if (mem_ack) state_d = ST_COMPARE;
      ST_RESPOND:   state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_we    <= 1'b0;
      req_tag   <= '0;
      req_idx   <= '0;
      req_sel   <= '0;
      req_wdata <= '0;
      rdata_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && cpu_req) begin
        req_we    <= cpu_we;
        req_tag   <= addr_tag(cpu_addr);
        req_idx   <= addr_idx(cpu_addr);
        req_sel   <= addr_sel(cpu_addr);
        req_wdata <= cpu_wdata;
      end
      if (lookup_hit) rdata_q <= req_we ? req_wdata : pick_word(lk_data, req_sel);
    end
  end

  assign lk_idx    = req_idx;
  assign fill_en   = (state_q == ST_REFILL) && mem_ack;
  assign fill_tag  = req_tag;
  assign wr_en     = lookup_hit && req_we;
  assign wr_sel    = req_sel;
  assign wr_data   = req_wdata;
  assign mem_req   = (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
  assign mem_we    = (state_q == ST_WRITEBACK);
  assign mem_blk   = (state_q == ST_WRITEBACK) ? {lk_tag, req_idx} : {req_tag, req_idx};
  assign cpu_ready = (state_q == ST_RESPOND);
  assign cpu_rdata = rdata_q;
  assign cpu_stall = mem_req;

  AST_HIT_THEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_hit |=> (cpu_ready && !mem_req)); // R3
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_blk))); // R4
  AST_WB_ONLY_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && mem_we) |-> $past(lookup_miss && victim_dirty)); // R6
  AST_REFILL_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack) |=> (mem_req && !mem_we)); // R6
  AST_CLEAN_NO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_miss && !victim_dirty) |=> (mem_req && !mem_we)); // R9
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> lookup_hit); // R7
  AST_STALL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cpu_stall && cpu_ready)); // R8
endmodule

// File: rtl/dmc_top.sv
module dmc_top #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 32,
  parameter int BLOCK_BYTES = 16,
  parameter int LINES = 4,
  localparam int WORDS = BLOCK_BYTES * 8 / WORD_W,
  localparam int SEL_W = $clog2(WORDS),
  localparam int OFF_W = $clog2(BLOCK_BYTES),
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
  localparam int BN_W = ADDR_W - OFF_W,
  localparam int BLK_W = BLOCK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [WORD_W-1:0] cpu_wdata,
  output logic [WORD_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              cpu_stall,
  output logic              mem_req,
  output logic              mem_we,
  output logic [BN_W-1:0]   mem_blk,
  output logic [BLK_W-1:0]  mem_wdata,
  input  logic [BLK_W-1:0]  mem_rdata,
  input  logic              mem_ack
);
  logic [IDX_W-1:0]  lk_idx;
  logic              lk_valid, lk_dirty;
  logic [TAG_W-1:0]  lk_tag;
  logic [BLK_W-1:0]  lk_data;
  logic              fill_en, wr_en;
  logic [TAG_W-1:0]  fill_tag;
  logic [SEL_W-1:0]  wr_sel;
  logic [WORD_W-1:0] wr_data;

  dmc_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .BLOCK_BYTES(BLOCK_BYTES), .LINES(LINES)) u_ctrl (
    .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_rdata, .cpu_ready, .cpu_stall,
    .mem_req, .mem_we, .mem_blk, .mem_ack,
    .lk_idx, .lk_valid, .lk_dirty, .lk_tag, .lk_data,
    .fill_en, .fill_tag, .wr_en, .wr_sel, .wr_data
  );

  dmc_lines #(.LINES(LINES), .TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_lines (
    .clk, .rst_n, .lk_idx, .lk_valid, .lk_dirty, .lk_tag, .lk_data,
    .fill_en, .fill_tag, .fill_data(mem_rdata),
    .wr_en, .wr_sel, .wr_data
  );

  assign mem_wdata = lk_data;
endmodule

// File: tb/dmc_top_tb.sv
module dmc_top_tb;
  localparam int CLK_PERIOD = 10;

  logic         clk = 0, rst_n = 0;
  logic         cpu_req = 0, cpu_we = 0;
  logic [6:0]   cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0, cpu_rdata;
  logic         cpu_ready, cpu_stall;
  logic         mem_req, mem_we, mem_ack = 0;
  logic [2:0]   mem_blk;
  logic [127:0] mem_wdata, mem_rdata = '0;

  dmc_top u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0, resp_n = 0, resp_cyc = 0, stall_cnt = 0;
  int req_cyc, lat, ev_n = 0, ev0, stall0;
  bit done = 0;
  logic [127:0] backing [8];
  logic [31:0]  ref_mem [32];
  bit           ev_we  [64];
  logic [2:0]   ev_blk [64];
  logic [31:0]  exp_q [$];

  function automatic logic [31:0] seed_word(int b, int w);
    return 32'hC0DE_0000 + 32'(b * 16 + w);
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expected data at each completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_stall) stall_cnt++;
      check(!(cpu_stall && cpu_ready), "R8 stall with ready", {cpu_stall, cpu_ready}, 0);
      if (cpu_ready) begin
        if (exp_q.size() == 0) check(0, "R3 unexpected completion", cpu_rdata, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          check(cpu_rdata === e, "R3/R4/R5 returned word", cpu_rdata, e);
        end
        resp_cyc = cyc;
        resp_n++;
      end
    end
  end

  // next-level memory model with transfer log
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_req) begin
        repeat (2) @(negedge clk);
        ev_we[ev_n % 64] = mem_we;
        ev_blk[ev_n % 64] = mem_blk;
        ev_n++;
        if (mem_we) backing[mem_blk] = mem_wdata;
        else mem_rdata = backing[mem_blk];
        mem_ack = 1;
        @(negedge clk);
        mem_ack = 0;
      end
    end
  end

  task automatic access(input bit we, input logic [6:0] addr, input logic [31:0] wd);
    int start;
    @(negedge clk);
    exp_q.push_back(we ? wd : ref_mem[addr[6:2]]);
    if (we) ref_mem[addr[6:2]] = wd;
    ev0 = ev_n; stall0 = stall_cnt; start = resp_n;
    cpu_req = 1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd; req_cyc = cyc;
    @(negedge clk);
    cpu_req = 0;
    while (resp_n == start) @(posedge clk);
    lat = resp_cyc - req_cyc;
  endtask

  task automatic expect_hit(input string req);
    check(lat == 2, {req, " hit latency"}, lat, 2);
    check(ev_n == ev0, {req, " no memory transfer on hit"}, ev_n - ev0, 0);
    check(stall_cnt == stall0, "R8 no stall on hit", stall_cnt - stall0, 0);
  endtask

  task automatic expect_xfers(input string req, input int n, input bit we0, input int b0,
                              input bit we1, input int b1);
    check(ev_n - ev0 == n, {req, " transfer count"}, ev_n - ev0, n);
    if (n >= 1) check(ev_we[ev0%64] == we0 && ev_blk[ev0%64] == 3'(b0),
                      {req, " first transfer"}, {ev_we[ev0%64], ev_blk[ev0%64]}, {we0, 3'(b0)});
    if (n >= 2) check(ev_we[(ev0+1)%64] == we1 && ev_blk[(ev0+1)%64] == 3'(b1),
                      {req, " second transfer"}, {ev_we[(ev0+1)%64], ev_blk[(ev0+1)%64]}, {we1, 3'(b1)});
    check(stall_cnt > stall0, "R8 stall during miss", stall_cnt - stall0, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    for (int b = 0; b < 8; b++)
      for (int w = 0; w < 4; w++) begin
        backing[b][w*32 +: 32] = seed_word(b, w);
        ref_mem[b*4 + w] = seed_word(b, w);
      end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2: reset state at the ports
    check(!cpu_ready && !cpu_stall && !mem_req, "R2 reset outputs", {cpu_ready, cpu_stall, mem_req}, 0);

    // R2/R4: first access to line 0 misses and only reads block 0
    access(0, 7'h04, 0);
    expect_xfers("R2 R4 cold read miss", 1, 0, 0, 0, 0);
    // R3/R1: other word of same block hits
    access(0, 7'h0C, 0);
    expect_hit("R3");
    // R1: byte offset ignored
    access(0, 7'h0E, 0);
    expect_hit("R1");
    // R5: store hit, backing unchanged
    access(1, 7'h08, 32'hDEAD_BEEF);
    expect_hit("R5");
    check(backing[0][64 +: 32] == seed_word(0, 2), "R5 memory untouched by store hit",
          backing[0][64 +: 32], seed_word(0, 2));
    access(0, 7'h08, 0);
    expect_hit("R5 readback");
    // R6: aliasing block 4 evicts dirty block 0
    access(0, 7'h48, 0);
    expect_xfers("R6 dirty eviction", 2, 1, 0, 0, 4);
    check(backing[0][64 +: 32] == 32'hDEAD_BEEF, "R6 written-back word",
          backing[0][64 +: 32], 32'hDEAD_BEEF);
    check(backing[0][32 +: 32] == seed_word(0, 1), "R6 written-back other word",
          backing[0][32 +: 32], seed_word(0, 1));
    // R9: clean victim block 4 not written back
    access(0, 7'h08, 0);
    expect_xfers("R9 clean eviction", 1, 0, 0, 0, 0);
    // R7/R2: store miss into never-valid line 3: read only
    access(1, 7'h74, 32'h1234_5678);
    expect_xfers("R7 R2 store miss on invalid line", 1, 0, 7, 0, 0);
    check(backing[7][32 +: 32] == seed_word(7, 1), "R7 store miss leaves memory",
          backing[7][32 +: 32], seed_word(7, 1));
    access(0, 7'h74, 0);
    expect_hit("R7 readback");
    access(0, 7'h78, 0);
    expect_hit("R7 neighbour word");
    // R7/R6: dirty store-miss line evicted by block 3
    access(0, 7'h34, 0);
    expect_xfers("R7 R6 evict allocated line", 2, 1, 7, 0, 3);
    check(backing[7][32 +: 32] == 32'h1234_5678, "R7 merged word written back",
          backing[7][32 +: 32], 32'h1234_5678);
    check(backing[7][0 +: 32] == seed_word(7, 0), "R7 fetched word kept",
          backing[7][0 +: 32], seed_word(7, 0));
    // R1: index lines 1 and 2 independent of 0 and 3
    access(0, 7'h10, 0);
    expect_xfers("R1 line 1 miss", 1, 0, 1, 0, 0);
    access(0, 7'h64, 0);
    expect_xfers("R1 line 2 miss", 1, 0, 6, 0, 0);
    access(0, 7'h1C, 0);
    expect_hit("R1 line 1 kept");
    access(0, 7'h34, 0);
    expect_hit("R1 line 3 kept");
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all completions seen", exp_q.size(), 0);
    finish_run();
  end
endmodule